// File: doc/BRIEF.md
# Set-Once Decrement-Only Lifetime Counter

This block keeps the remaining life of a consumable as a 17-bit count. The count starts at zero and may be given a starting value exactly once. That takes two requests. A stage request first places a 32-bit word in a holding buffer, and a commit request then moves the low 17 bits into the count. After the commit, the only change the count accepts is a decrement of one per request. The current count is always visible, zero-extended to 32 bits.

Each request produces a one-byte status that appears one clock after the request and holds until the next request:

| Code | Meaning |
|------|---------|
| AAh | success |
| 33h | nothing to act on (the count is already zero, or the commit has no staged word) |
| 55h | the operation is not allowed in the current state (no preset yet, or the preset is already used) |
| 77h | a tamper event has been seen |

A tamper input is latched until reset. From then on, every decrement is refused.

Top module: `lifetime_ctr`

## Requirements
- R1: After reset the count is 0, the preset flag is 0 and the status byte is 00h.
- R2: A stage request (`stage_i`) keeps bits [16:0] of `preset_word_i` in the buffer and marks it pending. It answers AAh and leaves the count unchanged.
- R3: A commit (`commit_i`) copies the buffered 17-bit value into the count, but only when a staged word is pending and no preset has been done. It then sets the preset flag and answers AAh.
- R4: A commit with no pending staged word answers 33h and changes nothing. The pending mark is cleared by every commit, decrement or read request, so only a stage request placed directly before the commit counts.
- R5: A commit after a successful preset answers 55h. The count and the preset flag are unchanged. The preset flag never returns to 0 except by reset.
- R6: A decrement on a preset, non-zero count with no tamper answers AAh and lowers the count by exactly 1.
- R7: A decrement at count 0 (preset, no tamper) answers 33h and the count stays 0.
- R8: A decrement before any preset answers 55h and the count stays 0.
- R9: A high level on `tamper_i` in any cycle is latched until reset. A decrement in that cycle or any later one answers 77h and leaves the count unchanged. This outcome takes priority over the 55h and 33h outcomes.
- R10: A read request (`read_i`) answers AAh. `count_o` always shows the count with bits [31:17] zero.
- R11: When strobes coincide, only one request is served, in the order commit, decrement, stage, read. The status changes only in the cycle after a request, and the count can rise only in the cycle after a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_word_i | input | 32 | Word offered by a stage request |
| stage_i | input | 1 | Stage request: load the buffer |
| commit_i | input | 1 | Commit request: buffer to count |
| dec_i | input | 1 | Decrement request |
| read_i | input | 1 | Read request |
| tamper_i | input | 1 | Tamper indication, latched |
| count_o | output | 32 | Current count, zero-extended |
| preset_o | output | 1 | Count has been preset |
| status_o | output | 8 | Status of the latest request |

## Verification
On every cycle, the assertions check the following:
- the upper bits of the count stay at zero;
- the count never rises without a commit;
- once set, the preset flag stays set and the count is frozen unless a decrement arrives;
- a decrement arriving with the tamper input high answers 77h;
- a decrement at zero leaves the count at zero with a refusal code.

The bench scenarios cover the behaviours that depend on history:
- the pending mark being cleared by an intervening request;
- the exact value the count takes from a staged word;
- a tamper pulse seen many cycles before the decrement it blocks;
- the order in which coinciding strobes are served.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_COMMIT,
    REQ_DEC,
    REQ_STAGE,
    REQ_READ
  } lc_req_e;

  localparam logic [7:0] ST_IDLE   = 8'h00;
  localparam logic [7:0] ST_OK     = 8'hAA;
  localparam logic [7:0] ST_EMPTY  = 8'h33;
  localparam logic [7:0] ST_DENY   = 8'h55;
  localparam logic [7:0] ST_TAMPER = 8'h77;
endpackage

// File: rtl/lc_req_arb.sv
module lc_req_arb
  import lc_pkg::*;
(
  input  logic    commit_i,
  input  logic    dec_i,
  input  logic    stage_i,
  input  logic    read_i,
  output lc_req_e req_o
);
  // fixed priority: commit, decrement, stage, read
  always_comb begin
    if (commit_i)     req_o = REQ_COMMIT;
    else if (dec_i)   req_o = REQ_DEC;
    else if (stage_i) req_o = REQ_STAGE;
    else if (read_i)  req_o = REQ_READ;
    else              req_o = REQ_NONE;
  end
endmodule

// File: rtl/lc_stage_buf.sv
module lc_stage_buf
  import lc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lc_req_e           req_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  val_o,
  output logic              pend_o
);
  logic [CNT_W-1:0] val_q, val_d;
  logic             pend_q, pend_d;
  logic             val_en, pend_en;

  always_comb begin
    val_en  = (req_i == REQ_STAGE);
    val_d   = word_i[CNT_W-1:0];
    pend_en = (req_i != REQ_NONE);
    pend_d  = (req_i == REQ_STAGE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (val_en)  val_q  <= val_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign val_o  = val_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/lc_count_core.sv
module lc_count_core
  import lc_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lc_req_e          req_i,
  input  logic [CNT_W-1:0] stage_val_i,
  input  logic             stage_pend_i,
  input  logic             tamper_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             preset_o,
  output logic [7:0]       status_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_q, pre_d;
  logic [7:0]       st_q, st_d;
  logic             tamp_q, tamp_d;
  logic             tamp_now;
  logic             cnt_en, pre_en, st_en, tamp_en;

  assign tamp_now = tamp_q | tamper_i;

  always_comb begin
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    st_d    = st_q;
    cnt_en  = 1'b0;
    pre_en  = 1'b0;
    st_en   = (req_i != REQ_NONE);
    tamp_d  = 1'b1;
    tamp_en = tamper_i & ~tamp_q;
    unique case (req_i)
      REQ_COMMIT: begin
        if (!stage_pend_i)  st_d = ST_EMPTY;
        else if (pre_q)     st_d = ST_DENY;
        else begin
          cnt_d  = stage_val_i;
          pre_d  = 1'b1;
          cnt_en = 1'b1;
          pre_en = 1'b1;
          st_d   = ST_OK;
        end
      end
      REQ_DEC: begin
        if (tamp_now)           st_d = ST_TAMPER;
        else if (!pre_q)        st_d = ST_DENY;
        else if (cnt_q == '0)   st_d = ST_EMPTY;
        else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
          st_d   = ST_OK;
        end
      end
      REQ_STAGE, REQ_READ: st_d = ST_OK;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= 1'b0;
      st_q   <= ST_IDLE;
      tamp_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (pre_en)  pre_q  <= pre_d;
      if (st_en)   st_q   <= st_d;
      if (tamp_en) tamp_q <= tamp_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign preset_o = pre_q;
  assign status_o = st_q;
endmodule

// File: rtl/lifetime_ctr.sv
module lifetime_ctr
  import lc_pkg::*;
#(
  parameter int CNT_W  = 17,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] preset_word_i,
  input  logic              stage_i,
  input  logic              commit_i,
  input  logic              dec_i,
  input  logic              read_i,
  input  logic              tamper_i,
  output logic [WORD_W-1:0] count_o,
  output logic              preset_o,
  output logic [7:0]        status_o
);
  localparam int PAD_W = WORD_W - CNT_W;

  lc_req_e          req;
  logic [CNT_W-1:0] stage_val;
  logic             stage_pend;
  logic [CNT_W-1:0] cnt;

  lc_req_arb u_arb (
    .commit_i (commit_i),
    .dec_i    (dec_i),
    .stage_i  (stage_i),
    .read_i   (read_i),
    .req_o    (req)
  );

  lc_stage_buf #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req),
    .word_i (preset_word_i),
    .val_o  (stage_val),
    .pend_o (stage_pend)
  );

  lc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .stage_val_i  (stage_val),
    .stage_pend_i (stage_pend),
    .tamper_i     (tamper_i),
    .cnt_o        (cnt),
    .preset_o     (preset_o),
    .status_o     (status_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign count_o = {{PAD_W{1'b0}}, cnt};
    end else begin : g_nopad
      assign count_o = cnt[WORD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lc_chk.sv
module lc_chk #(
  parameter int CNT_W  = 17,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stage_i,
  input logic              commit_i,
  input logic              dec_i,
  input logic              read_i,
  input logic              tamper_i,
  input logic [WORD_W-1:0] count_o,
  input logic              preset_o,
  input logic [7:0]        status_o
);
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o[WORD_W-1:CNT_W] == '0);

  // R11
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> count_o <= $past(count_o));

  // R5
  preset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_o |=> preset_o);

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_o && !dec_i |=> $stable(count_o));

  // R9
  tamper_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_i && dec_i && !commit_i |=> status_o == 8'h77 && $stable(count_o));

  // R7
  zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i && !commit_i && count_o == '0 |=>
      count_o == '0 && status_o != 8'hAA);

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stage_i || commit_i || dec_i || read_i) |=> $stable(status_o));
endmodule

bind lifetime_ctr lc_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_lc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stage_i  (stage_i),
  .commit_i (commit_i),
  .dec_i    (dec_i),
  .read_i   (read_i),
  .tamper_i (tamper_i),
  .count_o  (count_o),
  .preset_o (preset_o),
  .status_o (status_o)
);

// File: tb/lifetime_ctr_bench.sv
`timescale 1ns/1ps
module lifetime_ctr_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] preset_word_i;
  logic        stage_i, commit_i, dec_i, read_i, tamper_i;
  logic [31:0] count_o;
  logic        preset_o;
  logic [7:0]  status_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_cnt, m_st, m_pend, m_buf;
  bit m_pre, m_tamp;

  lifetime_ctr u_lifetime_ctr (
    .clk           (clk),
    .rst_n         (rst_n),
    .preset_word_i (preset_word_i),
    .stage_i       (stage_i),
    .commit_i      (commit_i),
    .dec_i         (dec_i),
    .read_i        (read_i),
    .tamper_i      (tamper_i),
    .count_o       (count_o),
    .preset_o      (preset_o),
    .status_o      (status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_st = 0; m_pend = 0; m_buf = 0; m_tamp = 0;
    end else begin
      bit t;
      t = m_tamp || tamper_i;
      if (commit_i) begin
        if (m_pend == 0) m_st = 'h33;
        else if (m_pre)  m_st = 'h55;
        else begin m_cnt = m_buf; m_pre = 1; m_st = 'hAA; end
        m_pend = 0;
      end else if (dec_i) begin
        if (t)               m_st = 'h77;
        else if (!m_pre)     m_st = 'h55;
        else if (m_cnt == 0) m_st = 'h33;
        else begin m_cnt = m_cnt - 1; m_st = 'hAA; end
        m_pend = 0;
      end else if (stage_i) begin
        m_buf = preset_word_i % 131072; m_pend = 1; m_st = 'hAA;
      end else if (read_i) begin
        m_pend = 0; m_st = 'hAA;
      end
      m_tamp = t;
    end
  end

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk(int'(count_o), m_cnt, tag, "count");
    chk(int'(preset_o), int'(m_pre), tag, "preset");
    chk(int'(status_o), m_st, tag, "status");
  endtask

  task automatic op(input bit c, input bit d, input bit s, input bit r,
                    input bit t, input logic [31:0] w, input string tag);
    commit_i = c; dec_i = d; stage_i = s; read_i = r; tamper_i = t;
    preset_word_i = w;
    @(negedge clk);
    commit_i = 0; dec_i = 0; stage_i = 0; read_i = 0; tamper_i = 0;
    cmp_model(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; preset_word_i = 0;
    stage_i = 0; commit_i = 0; dec_i = 0; read_i = 0; tamper_i = 0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(int'(count_o), 0, "R1", "count");
    chk(int'(preset_o), 0, "R1", "preset");
    chk(int'(status_o), 0, "R1", "status");

    op(0,1,0,0,0,0, "R8");            // decrement before preset
    chk(int'(status_o), 'h55, "R8", "status literal");
    op(1,0,0,0,0,0, "R4");            // commit with nothing staged
    chk(int'(status_o), 'h33, "R4", "status literal");
    op(0,0,1,0,0,32'hFFFE0005, "R2"); // stage, count untouched
    chk(int'(count_o), 0, "R2", "count after stage");
    op(0,0,0,1,0,0, "R10");           // read clears pending
    op(1,0,0,0,0,0, "R4");
    chk(int'(status_o), 'h33, "R4", "stale stage");
    op(0,0,1,0,0,32'hABC00003, "R2");
    op(1,0,0,0,0,0, "R3");
    chk(int'(count_o), 3, "R3", "count literal");
    chk(int'(preset_o), 1, "R3", "preset literal");
    op(0,0,1,0,0,32'h00001234, "R2");
    op(1,0,0,0,0,0, "R5");
    chk(int'(status_o), 'h55, "R5", "second preset");
    chk(int'(count_o), 3, "R5", "count kept");
    for (int i = 0; i < 3; i++) op(0,1,0,0,0,0, "R6");
    chk(int'(count_o), 0, "R6", "after three steps");
    op(0,1,0,0,0,0, "R7");
    chk(int'(status_o), 'h33, "R7", "floor status");
    op(0,0,0,1,0,0, "R10");
    chk(int'(status_o), 'hAA, "R10", "read status");
    op(1,1,0,0,0,0, "R11");           // commit wins
    op(0,1,1,1,0,32'h7, "R11");       // decrement wins
    op(0,0,1,1,0,32'h9, "R11");       // stage wins, pending set
    op(1,0,0,0,0,0, "R11");
    chk(int'(status_o), 'h55, "R11", "stage served before read");
    repeat (3) op(0,0,0,0,0,0, "R11"); // idle: status holds

    do_reset();
    op(0,0,1,0,0,32'hFFFFFFFF, "R2");
    op(1,0,0,0,0,0, "R3");
    chk(int'(count_o), 'h1FFFF, "R2", "low 17 bits kept");
    op(0,1,0,0,0,0, "R6");
    chk(int'(count_o), 'h1FFFE, "R6", "step from max");
    op(0,0,0,0,1,0, "R9");            // tamper pulse alone
    repeat (5) op(0,0,0,0,0,0, "R9");
    op(0,1,0,0,0,0, "R9");
    chk(int'(status_o), 'h77, "R9", "latched tamper");
    chk(int'(count_o), 'h1FFFE, "R9", "count frozen");
    op(0,0,0,1,0,0, "R10");

    do_reset();
    op(0,1,0,0,1,0, "R9");            // tamper beats not-preset
    chk(int'(status_o), 'h77, "R9", "priority over 55h");
    op(0,0,0,0,0,0, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule